// File: doc/BRIEF.md
# SMBus Host Register Unit

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through a simple 8-bit port with eight consecutive offsets. Through that port it programs the target address, the command byte, two data bytes and the protocol, and it launches a transaction by writing to the start offset. The block sends a one-cycle start strobe, the selected protocol, and the abort, bus-timeout and block-clear strobes to a separate transaction sequencer. The sequencer reports completion or an error back through event inputs, and it can load the two data bytes with bytes it has read.

The status byte holds sticky flags for completion, device error, collision or missing acknowledge (one shared bit), and abort termination. It also holds a busy flag and an idle bit that always reads as the inverse of busy. Software clears a flag by writing a 1 to its bit. The block data offset does not store anything itself: it forwards writes and read requests to an external block buffer.

Top module: `smbh_regfile`

## Requirements
- R1: The slave address (offset 3), data 0 (offset 4), data 1 (offset 5) and command (offset 7) registers read back what was written. A read returns its data on `bus_rdata` one clock after the cycle in which `bus_rd` was sampled.
- R2: The status byte at offset 0 has the layout: bit 2 idle, bit 3 busy, bit 4 done, bit 5 device error, bit 6 collision or no acknowledge, bit 7 terminated by abort. Bits 1:0 read 0, and the value after reset is 0x04.
- R3: Writing a 1 to any of status bits 7:3 clears that flag, and writing a 0 leaves it unchanged. If a set event arrives in the same cycle as the clearing write, the flag stays set.
- R4: Any write to offset 2 while busy is clear produces `start_pulse` for exactly one cycle in the cycle after the write, and it sets busy. `proto_sel` carries control bits 6:4 (0 quick, 1 byte, 2 byte data, 3 word data, 4 block).
- R5: A write to offset 2 while busy is set produces no start pulse.
- R6: `ev_done`, `ev_dev_err` or `ev_coll` sets its own flag (bit 4, 5 or 6) and clears busy, so idle reads 1 again.
- R7: A control write (offset 1) with bit 1 set produces a one-cycle `abort_pulse`, sets the terminated flag and clears busy.
- R8: A control write with bit 2 set produces a one-cycle `tmo_pulse` and clears busy without setting any error flag.
- R9: A control write with bit 7 set produces a one-cycle `blkclr_pulse`. The control register stores only bits 6:4, so writing 0xC6 reads back as 0x40.
- R10: `ev_dat_we` loads data 0 and data 1 from the sequencer. It takes priority over a host write to those offsets in the same cycle.
- R11: A write to offset 6 gives `blk_wr_pulse` with `blk_wdata` equal to the written byte in the next cycle. A read of offset 6 returns `blk_rdata` and gives `blk_rd_pulse` in the next cycle.
- R12: Offset 2 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| start_pulse | output | 1 | Transaction launch strobe |
| proto_sel | output | 3 | Selected protocol |
| abort_pulse | output | 1 | Abort strobe |
| tmo_pulse | output | 1 | Bus timeout reset strobe |
| blkclr_pulse | output | 1 | Block buffer pointer clear strobe |
| slave_addr | output | 8 | Address byte with the direction bit |
| cmd_byte | output | 8 | Command byte |
| data0 | output | 8 | Data byte 0 |
| data1 | output | 8 | Data byte 1 |
| ev_done | input | 1 | Sequencer: transaction complete |
| ev_dev_err | input | 1 | Sequencer: device error |
| ev_coll | input | 1 | Sequencer: collision or no acknowledge |
| ev_dat_we | input | 1 | Sequencer: load data bytes |
| ev_dat0 | input | 8 | Sequencer data 0 |
| ev_dat1 | input | 8 | Sequencer data 1 |
| blk_wr_pulse | output | 1 | Block buffer write strobe |
| blk_wdata | output | 8 | Block buffer write byte |
| blk_rd_pulse | output | 1 | Block buffer read advance strobe |
| blk_rdata | input | 8 | Block buffer read byte |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a sequencer event that sets a status flag and a software write-one-to-clear of that same flag. The second pair is a sequencer load of the data bytes and a host write to data 0. The bench drives both sides on the same clock edge. It expects the flag to stay set and the sequencer byte to win, and it judges the result by reading status and data 0 back through the port.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int unsigned OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_STS   = 3'd0;
  localparam logic [OFS_W-1:0] OFS_CTL   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_START = 3'd2;
  localparam logic [OFS_W-1:0] OFS_SLV   = 3'd3;
  localparam logic [OFS_W-1:0] OFS_DAT0  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_DAT1  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_BLK   = 3'd6;
  localparam logic [OFS_W-1:0] OFS_CMD   = 3'd7;
  // status bit positions
  localparam int unsigned SB_IDLE = 2;
  localparam int unsigned SB_BUSY = 3;
  localparam int unsigned SB_DONE = 4;
  localparam int unsigned SB_DEV  = 5;
  localparam int unsigned SB_COLL = 6;
  localparam int unsigned SB_TERM = 7;
  // control bit positions
  localparam int unsigned CB_ABORT = 1;
  localparam int unsigned CB_TMO   = 2;
  localparam int unsigned CB_PLO   = 4;
  localparam int unsigned CB_PHI   = 6;
  localparam int unsigned CB_BCLR  = 7;
  localparam int unsigned PROTO_W  = CB_PHI - CB_PLO + 1;
endpackage

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_sts,
  input  logic [7:3] clr_bits,
  input  logic       start_req,
  input  logic       abort_req,
  input  logic       tmo_req,
  input  logic       ev_done,
  input  logic       ev_dev_err,
  input  logic       ev_coll,
  output logic       start_acc,
  output logic       busy,
  output logic [7:0] sts_byte
);
  logic done_q, dev_q, coll_q, term_q, busy_q;
  logic [7:3] clr;
  logic end_evt;

  assign clr       = wr_sts ? clr_bits : 5'b0;
  assign start_acc = start_req & ~busy_q;
  assign end_evt   = ev_done | ev_dev_err | ev_coll | abort_req | tmo_req | clr[SB_BUSY];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dev_q  <= 1'b0;
      coll_q <= 1'b0;
      term_q <= 1'b0;
    end else begin
      if (start_acc)    busy_q <= 1'b1;
      else if (end_evt) busy_q <= 1'b0;
      // set events take priority over write-one-to-clear
      if (ev_done)           done_q <= 1'b1;
      else if (clr[SB_DONE]) done_q <= 1'b0;
      if (ev_dev_err)        dev_q  <= 1'b1;
      else if (clr[SB_DEV])  dev_q  <= 1'b0;
      if (ev_coll)           coll_q <= 1'b1;
      else if (clr[SB_COLL]) coll_q <= 1'b0;
      if (abort_req)         term_q <= 1'b1;
      else if (clr[SB_TERM]) term_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign sts_byte = {term_q, coll_q, dev_q, done_q, busy_q, ~busy_q, 2'b00};

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> busy);  // R4
  AST_EVENT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((ev_done | ev_dev_err | ev_coll) && !start_acc) |=> !busy);  // R6
  AST_W1C_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && clr_bits[SB_DONE] && !ev_done) |=> !sts_byte[SB_DONE]);  // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_coll |=> sts_byte[SB_COLL]);  // R3
  AST_ABORT_TERM: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> (sts_byte[SB_TERM] && !busy));  // R7
  AST_TMO_FREE: assert property (@(posedge clk) disable iff (rst)
    (tmo_req && !start_acc) |=> !busy);  // R8
endmodule

// File: rtl/smbh_cmd.sv
module smbh_cmd
  import smbh_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_ctl,
  input  logic               wr_start,
  input  logic [PROTO_W-1:0] proto_in,
  input  logic               abort_bit,
  input  logic               tmo_bit,
  input  logic               bclr_bit,
  input  logic               busy,
  input  logic               start_acc,
  output logic               abort_req,
  output logic               tmo_req,
  output logic [PROTO_W-1:0] proto,
  output logic               start_pulse,
  output logic               abort_pulse,
  output logic               tmo_pulse,
  output logic               blkclr_pulse
);
  assign abort_req = wr_ctl & abort_bit;
  assign tmo_req   = wr_ctl & tmo_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      proto        <= '0;
      start_pulse  <= 1'b0;
      abort_pulse  <= 1'b0;
      tmo_pulse    <= 1'b0;
      blkclr_pulse <= 1'b0;
    end else begin
      if (wr_ctl) proto <= proto_in;
      start_pulse  <= start_acc;
      abort_pulse  <= abort_req;
      tmo_pulse    <= tmo_req;
      blkclr_pulse <= wr_ctl & bclr_bit;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_start && busy) |=> !start_pulse);  // R5
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);  // R4
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |=> !abort_pulse);  // R7
endmodule

// File: rtl/smbh_data.sv
module smbh_data
  import smbh_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             ev_dat_we,
  input  logic [DW-1:0]    ev_dat0,
  input  logic [DW-1:0]    ev_dat1,
  output logic [DW-1:0]    slave_addr,
  output logic [DW-1:0]    cmd_byte,
  output logic [DW-1:0]    data0,
  output logic [DW-1:0]    data1,
  output logic             blk_wr_pulse,
  output logic [DW-1:0]    blk_wdata,
  output logic             blk_rd_pulse
);
  logic wr_slv, wr_cmd, wr_d0, wr_d1, wr_blk, rd_blk;
  assign wr_slv = bus_wr && bus_addr == OFS_SLV;
  assign wr_cmd = bus_wr && bus_addr == OFS_CMD;
  assign wr_d0  = bus_wr && bus_addr == OFS_DAT0;
  assign wr_d1  = bus_wr && bus_addr == OFS_DAT1;
  assign wr_blk = bus_wr && bus_addr == OFS_BLK;
  assign rd_blk = bus_rd && bus_addr == OFS_BLK;

  always_ff @(posedge clk) begin
    if (rst) begin
      slave_addr   <= '0;
      cmd_byte     <= '0;
      data0        <= '0;
      data1        <= '0;
      blk_wr_pulse <= 1'b0;
      blk_wdata    <= '0;
      blk_rd_pulse <= 1'b0;
    end else begin
      if (wr_slv) slave_addr <= bus_wdata;
      if (wr_cmd) cmd_byte   <= bus_wdata;
      // sequencer load has priority over the host port
      if (ev_dat_we) begin
        data0 <= ev_dat0;
        data1 <= ev_dat1;
      end else begin
        if (wr_d0) data0 <= bus_wdata;
        if (wr_d1) data1 <= bus_wdata;
      end
      blk_wr_pulse <= wr_blk;
      if (wr_blk) blk_wdata <= bus_wdata;
      blk_rd_pulse <= rd_blk;
    end
  end

  AST_SEQ_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_dat_we |=> (data0 == $past(ev_dat0) && data1 == $past(ev_dat1)));  // R10
  AST_BLK_WR: assert property (@(posedge clk) disable iff (rst)
    wr_blk |=> (blk_wr_pulse && blk_wdata == $past(bus_wdata)));  // R11
endmodule

// File: rtl/smbh_regfile.sv
module smbh_regfile
  import smbh_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OFS_W-1:0]   bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               start_pulse,
  output logic [PROTO_W-1:0] proto_sel,
  output logic               abort_pulse,
  output logic               tmo_pulse,
  output logic               blkclr_pulse,
  output logic [DW-1:0]      slave_addr,
  output logic [DW-1:0]      cmd_byte,
  output logic [DW-1:0]      data0,
  output logic [DW-1:0]      data1,
  input  logic               ev_done,
  input  logic               ev_dev_err,
  input  logic               ev_coll,
  input  logic               ev_dat_we,
  input  logic [DW-1:0]      ev_dat0,
  input  logic [DW-1:0]      ev_dat1,
  output logic               blk_wr_pulse,
  output logic [DW-1:0]      blk_wdata,
  output logic               blk_rd_pulse,
  input  logic [DW-1:0]      blk_rdata
);
  logic wr_sts, wr_ctl, wr_start;
  logic start_acc, busy, abort_req, tmo_req;
  logic [7:0] sts_byte;
  logic [7:0] ctl_byte;

  assign wr_sts   = bus_wr && bus_addr == OFS_STS;
  assign wr_ctl   = bus_wr && bus_addr == OFS_CTL;
  assign wr_start = bus_wr && bus_addr == OFS_START;

  smbh_status u_status (
    .clk(clk), .rst(rst), .wr_sts(wr_sts), .clr_bits(bus_wdata[7:3]),
    .start_req(wr_start), .abort_req(abort_req), .tmo_req(tmo_req),
    .ev_done(ev_done), .ev_dev_err(ev_dev_err), .ev_coll(ev_coll),
    .start_acc(start_acc), .busy(busy), .sts_byte(sts_byte)
  );

  smbh_cmd u_cmd (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wr_start(wr_start),
    .proto_in(bus_wdata[CB_PHI:CB_PLO]), .abort_bit(bus_wdata[CB_ABORT]),
    .tmo_bit(bus_wdata[CB_TMO]), .bclr_bit(bus_wdata[CB_BCLR]),
    .busy(busy), .start_acc(start_acc), .abort_req(abort_req), .tmo_req(tmo_req),
    .proto(proto_sel), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .tmo_pulse(tmo_pulse), .blkclr_pulse(blkclr_pulse)
  );

  smbh_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ev_dat_we(ev_dat_we), .ev_dat0(ev_dat0),
    .ev_dat1(ev_dat1), .slave_addr(slave_addr), .cmd_byte(cmd_byte),
    .data0(data0), .data1(data1), .blk_wr_pulse(blk_wr_pulse),
    .blk_wdata(blk_wdata), .blk_rd_pulse(blk_rd_pulse)
  );

  assign ctl_byte = {1'b0, proto_sel, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        OFS_STS:   bus_rdata <= DW'(sts_byte);
        OFS_CTL:   bus_rdata <= DW'(ctl_byte);
        OFS_START: bus_rdata <= '0;
        OFS_SLV:   bus_rdata <= slave_addr;
        OFS_DAT0:  bus_rdata <= data0;
        OFS_DAT1:  bus_rdata <= data1;
        OFS_BLK:   bus_rdata <= blk_rdata;
        OFS_CMD:   bus_rdata <= cmd_byte;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  AST_IDLE_INV: assert property (@(posedge clk) disable iff (rst)
    sts_byte[SB_IDLE] != sts_byte[SB_BUSY]);  // R2
  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_START) |=> bus_rdata == '0);  // R12
endmodule

// File: tb/test_smbh_regfile.sv
`timescale 1ns/1ps
module test_smbh_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       start_pulse, abort_pulse, tmo_pulse, blkclr_pulse;
  logic [2:0] proto_sel;
  logic [7:0] slave_addr, cmd_byte, data0, data1, blk_wdata;
  logic       ev_done = 0, ev_dev_err = 0, ev_coll = 0, ev_dat_we = 0;
  logic [7:0] ev_dat0 = '0, ev_dat1 = '0, blk_rdata = '0;
  logic       blk_wr_pulse, blk_rd_pulse;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  bit         done_flag = 0;

  always #2.5 clk = ~clk;

  smbh_regfile i_smbh_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_pulse(start_pulse),
    .proto_sel(proto_sel), .abort_pulse(abort_pulse), .tmo_pulse(tmo_pulse),
    .blkclr_pulse(blkclr_pulse), .slave_addr(slave_addr), .cmd_byte(cmd_byte),
    .data0(data0), .data1(data1), .ev_done(ev_done), .ev_dev_err(ev_dev_err),
    .ev_coll(ev_coll), .ev_dat_we(ev_dat_we), .ev_dat0(ev_dat0), .ev_dat1(ev_dat1),
    .blk_wr_pulse(blk_wr_pulse), .blk_wdata(blk_wdata), .blk_rd_pulse(blk_rd_pulse),
    .blk_rdata(blk_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%02h exp=0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data from the scoreboard
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("scoreboard underflow R1", 8'h00, 8'h01);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic evt(input logic d, input logic e, input logic c);
    ev_done = d; ev_dev_err = e; ev_coll = c;
    @(negedge clk);
    ev_done = 0; ev_dev_err = 0; ev_coll = 0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 act=hung exp=complete");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    rd(3'd0, 8'h04, "R2 reset status");
    rd(3'd1, 8'h00, "R9 reset control");
    rd(3'd2, 8'h00, "R12 start reads zero");
    chk("R4 no start after reset", {7'b0, start_pulse}, 8'h00);
    // plain registers
    wr(3'd3, 8'hA5); wr(3'd7, 8'h3C); wr(3'd4, 8'h11); wr(3'd5, 8'h22);
    rd(3'd3, 8'hA5, "R1 slave addr");
    rd(3'd7, 8'h3C, "R1 command");
    rd(3'd4, 8'h11, "R1 data0");
    rd(3'd5, 8'h22, "R1 data1");
    // launch
    wr(3'd1, 8'h30);
    chk("R4 proto word", {5'b0, proto_sel}, 8'h03);
    wr(3'd2, 8'h00);
    chk("R4 start pulse high", {7'b0, start_pulse}, 8'h01);
    @(negedge clk);
    chk("R4 start pulse single", {7'b0, start_pulse}, 8'h00);
    rd(3'd0, 8'h08, "R2 busy status");
    wr(3'd2, 8'h5A);
    chk("R5 start while busy ignored", {7'b0, start_pulse}, 8'h00);
    // done with data load
    ev_dat0 = 8'h5A; ev_dat1 = 8'h6B; ev_dat_we = 1;
    evt(1, 0, 0);
    ev_dat_we = 0;
    rd(3'd0, 8'h14, "R6 done sets, busy drops");
    rd(3'd4, 8'h5A, "R10 seq data0");
    rd(3'd5, 8'h6B, "R10 seq data1");
    wr(3'd0, 8'h10);
    rd(3'd0, 8'h04, "R3 w1c done");
    // collision, zero write leaves it
    wr(3'd2, 8'h00);
    evt(0, 0, 1);
    rd(3'd0, 8'h44, "R6 collision flag");
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h44, "R3 zero write keeps flag");
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h04, "R3 0xFF clears all");
    // set and clear in same cycle
    wr(3'd2, 8'h00);
    ev_dev_err = 1;
    wr(3'd0, 8'h20);
    ev_dev_err = 0;
    rd(3'd0, 8'h24, "R3 set wins over clear");
    wr(3'd0, 8'hFF);
    // abort
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h02);
    chk("R7 abort pulse", {7'b0, abort_pulse}, 8'h01);
    @(negedge clk);
    chk("R7 abort pulse single", {7'b0, abort_pulse}, 8'h00);
    rd(3'd0, 8'h84, "R7 terminated, not busy");
    wr(3'd0, 8'hFF);
    // timeout
    wr(3'd1, 8'h30);
    wr(3'd2, 8'h00);
    rd(3'd0, 8'h08, "R8 busy before timeout");
    wr(3'd1, 8'h34);
    chk("R8 timeout pulse", {7'b0, tmo_pulse}, 8'h01);
    rd(3'd0, 8'h04, "R8 busy cleared, no flag");
    // block clear strobe and control storage
    wr(3'd1, 8'hC6);
    chk("R9 block clear pulse", {7'b0, blkclr_pulse}, 8'h01);
    @(negedge clk);
    chk("R9 block clear single", {7'b0, blkclr_pulse}, 8'h00);
    rd(3'd1, 8'h40, "R9 control keeps protocol only");
    wr(3'd0, 8'hFF);
    // busy cleared by writing bit 3
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h04, "R3 w1c busy");
    // sequencer load vs host write
    ev_dat0 = 8'hC3; ev_dat1 = 8'h3C; ev_dat_we = 1;
    wr(3'd4, 8'hEE);
    ev_dat_we = 0;
    rd(3'd4, 8'hC3, "R10 seq wins over host");
    // block port
    wr(3'd6, 8'h77);
    chk("R11 block write pulse", {7'b0, blk_wr_pulse}, 8'h01);
    chk("R11 block write data", blk_wdata, 8'h77);
    blk_rdata = 8'h99;
    rd(3'd6, 8'h99, "R11 block read data");
    chk("R11 block read pulse", {7'b0, blk_rd_pulse}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_up();
  end
endmodule